// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows the power state of a processor core on its bus clock. Five states are tracked: Normal, Stop-Grant, AutoHALT, a short snoop-service state, and Sleep. A stop-clock request moves the core from Normal to Stop-Grant. A halt pulse moves it from Normal to AutoHALT. A bus snoop seen in either of those two low-power states opens the snoop-service state. That state holds until the snoop is finished or an interrupt has been captured, and then goes back to the low-power state it came from. A sleep request is legal only in Stop-Grant, and in Sleep all internal clocks are gated.

The sequencer does not control clocks, caches or the snoop response. It publishes the state as a one-hot vector, an internal-clock enable and a snoop-responder enable. It also checks the incoming stimulus against the power protocol. Any illegal event sets a violation flag, which stays set until reset. Reset is asynchronous and active low. From any state, including Sleep, it returns the machine straight to Normal.

Top module: `lps_sequencer`

## Requirements
- R1: While reset is low, and after it is released, the state is Normal and the violation flag is 0.
- R2: In Normal, a sampled stop-clock request gives Stop-Grant on the next cycle. A halt pulse without a stop-clock request gives AutoHALT. When both are present, the stop-clock request wins.
- R3: In Stop-Grant, a low stop-clock request, with no snoop start and no sleep request, returns the machine to Normal. In AutoHALT, a wake event with no snoop start returns it to Normal.
- R4: A snoop start in Stop-Grant or AutoHALT gives the snoop state on the next cycle. The snoop state holds for as long as snoop-done is low.
- R5: Snoop-done in the snoop state returns the machine to the exact low-power state the snoop state was entered from.
- R6: Sleep is entered from Stop-Grant when the sleep request is high and no snoop starts. In Sleep, a low sleep request returns the machine to Stop-Grant.
- R7: A sleep request sampled in Normal, AutoHALT or the snoop state sets the violation flag and does not change the state.
- R8: In Sleep, any of the following sets the violation flag: snoop start, snoop-done, halt pulse, wake event, or a low stop-clock request. None of these moves the machine out of Sleep.
- R9: A snoop start in the cycle that enters Sleep, or in the cycle that leaves it, sets the violation flag. In Stop-Grant the snoop still takes priority over the sleep request.
- R10: A sleep request that drops after fewer than SLP_MIN consecutive high cycles sets the violation flag. The count includes the entry cycle, and the default is 2.
- R11: Once the violation flag is set, it stays set until reset.
- R12: Reset asserted in Sleep gives Normal without a pass through Stop-Grant.
- R13: The internal-clock enable is low only in Sleep. The snoop-responder enable is high only in Stop-Grant, AutoHALT and the snoop state.
- R14: The state output is one-hot. Bit 0 is Normal, bit 1 Stop-Grant, bit 2 AutoHALT, bit 3 snoop and bit 4 Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stpclk_req | input | 1 | Stop-clock request |
| sleep_req | input | 1 | Sleep request |
| halt_pulse | input | 1 | Halt instruction executed |
| wake_evt | input | 1 | Interrupt or wake event for AutoHALT |
| snoop_start | input | 1 | Snoop or interrupt transaction seen on the bus |
| snoop_done | input | 1 | Snoop serviced or interrupt captured |
| state_oh | output | 5 | One-hot power state |
| int_clk_en | output | 1 | Internal clock enable |
| snoop_resp_en | output | 1 | Low-power snoop responder enable |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
A wrong internal state shows up on the one-hot state output and on both enables one cycle after the edge that caused it. This is because every output is decoded from the state register alone. A lost return-origin bit stays hidden while the snoop is in progress. It appears only on the cycle after snoop-done, when the machine goes back to the wrong low-power state. An error in the pulse counter or in the violation detection shows only on the violation flag, one cycle after the offending sample. Because the flag is sticky, the error stays visible until the next reset.

// File: rtl/lps_pkg.sv
package lps_pkg;
    localparam int NUM_ST = 5;

    // one-hot bit positions (R14)
    localparam int IX_NORM = 0;
    localparam int IX_STPG = 1;
    localparam int IX_AHLT = 2;
    localparam int IX_SNP  = 3;
    localparam int IX_SLP  = 4;

    typedef logic [NUM_ST-1:0] st_oh_t;

    localparam st_oh_t OH_NORM = st_oh_t'(1) << IX_NORM;
    localparam st_oh_t OH_STPG = st_oh_t'(1) << IX_STPG;
    localparam st_oh_t OH_AHLT = st_oh_t'(1) << IX_AHLT;
    localparam st_oh_t OH_SNP  = st_oh_t'(1) << IX_SNP;
    localparam st_oh_t OH_SLP  = st_oh_t'(1) << IX_SLP;
endpackage

// File: rtl/lps_trans.sv
module lps_trans
    import lps_pkg::*;
(
    input  st_oh_t state_q,
    input  logic   ret_ah_q,
    input  logic   stpclk_req,
    input  logic   sleep_req,
    input  logic   halt_pulse,
    input  logic   wake_evt,
    input  logic   snoop_start,
    input  logic   snoop_done,
    output st_oh_t state_d,
    output logic   ret_ah_d
);
    always_comb begin
        state_d  = state_q;
        ret_ah_d = ret_ah_q;
        if (state_q == OH_NORM) begin
            // R2: stop-clock has priority over halt
            if (stpclk_req)      state_d = OH_STPG;
            else if (halt_pulse) state_d = OH_AHLT;
        end else if (state_q == OH_STPG) begin
            if (snoop_start) begin          // R4, R9: snoop beats sleep
                state_d  = OH_SNP;
                ret_ah_d = 1'b0;
            end else if (sleep_req) begin   // R6
                state_d = OH_SLP;
            end else if (!stpclk_req) begin // R3
                state_d = OH_NORM;
            end
        end else if (state_q == OH_AHLT) begin
            if (snoop_start) begin          // R4
                state_d  = OH_SNP;
                ret_ah_d = 1'b1;
            end else if (wake_evt) begin    // R3
                state_d = OH_NORM;
            end
        end else if (state_q == OH_SNP) begin
            if (snoop_done)                 // R5
                state_d = ret_ah_q ? OH_AHLT : OH_STPG;
        end else if (state_q == OH_SLP) begin
            if (!sleep_req) state_d = OH_STPG; // R6
        end else begin
            state_d = OH_NORM;
        end
    end
endmodule

// File: rtl/lps_guard.sv
module lps_guard
    import lps_pkg::*;
#(
    parameter int SLP_MIN = 2,
    parameter int CNT_W   = 2
) (
    input  st_oh_t             state_q,
    input  logic [CNT_W-1:0]   slp_cnt_q,
    input  logic               stpclk_req,
    input  logic               sleep_req,
    input  logic               halt_pulse,
    input  logic               wake_evt,
    input  logic               snoop_start,
    input  logic               snoop_done,
    output logic               bad
);
    logic in_stpg, in_slp, entry_cyc, exit_cyc;
    logic bad_place, bad_act, bad_edge, bad_short;

    always_comb begin
        in_stpg   = state_q[IX_STPG];
        in_slp    = state_q[IX_SLP];
        entry_cyc = in_stpg & sleep_req;
        exit_cyc  = in_slp & ~sleep_req;
        // R7: sleep request outside Stop-Grant / Sleep
        bad_place = sleep_req & ~(in_stpg | in_slp);
        // R8: bus activity while asleep
        bad_act   = in_slp & (snoop_start | snoop_done | halt_pulse
                              | wake_evt | ~stpclk_req);
        // R9: snoop at the edges of Sleep
        bad_edge  = (entry_cyc | exit_cyc) & snoop_start;
        // R10: too-short sleep request
        bad_short = exit_cyc & (slp_cnt_q < CNT_W'(SLP_MIN));
        bad       = bad_place | bad_act | bad_edge | bad_short;
    end
endmodule

// File: rtl/lps_sequencer.sv
module lps_sequencer
    import lps_pkg::*;
#(
    parameter int SLP_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stpclk_req,
    input  logic              sleep_req,
    input  logic              halt_pulse,
    input  logic              wake_evt,
    input  logic              snoop_start,
    input  logic              snoop_done,
    output logic [NUM_ST-1:0] state_oh,
    output logic              int_clk_en,
    output logic              snoop_resp_en,
    output logic              violation
);
    localparam int CNT_W = $clog2(SLP_MIN + 1);

    typedef struct packed {
        st_oh_t           state;
        logic             ret_ah;
        logic [CNT_W-1:0] slp_cnt;
        logic             viol;
    } regs_t;

    regs_t  r_d, r_q;
    st_oh_t state_nx;
    logic   ret_nx, bad;

    lps_trans u_trans (
        .state_q     (r_q.state),
        .ret_ah_q    (r_q.ret_ah),
        .stpclk_req  (stpclk_req),
        .sleep_req   (sleep_req),
        .halt_pulse  (halt_pulse),
        .wake_evt    (wake_evt),
        .snoop_start (snoop_start),
        .snoop_done  (snoop_done),
        .state_d     (state_nx),
        .ret_ah_d    (ret_nx)
    );

    lps_guard #(.SLP_MIN(SLP_MIN), .CNT_W(CNT_W)) u_guard (
        .state_q     (r_q.state),
        .slp_cnt_q   (r_q.slp_cnt),
        .stpclk_req  (stpclk_req),
        .sleep_req   (sleep_req),
        .halt_pulse  (halt_pulse),
        .wake_evt    (wake_evt),
        .snoop_start (snoop_start),
        .snoop_done  (snoop_done),
        .bad         (bad)
    );

    always_comb begin
        r_d        = r_q;
        r_d.state  = state_nx;
        r_d.ret_ah = ret_nx;
        // consecutive sleep-request cycles, saturating (R10)
        if (!sleep_req)
            r_d.slp_cnt = '0;
        else if (r_q.slp_cnt != CNT_W'(SLP_MIN))
            r_d.slp_cnt = r_q.slp_cnt + 1'b1;
        r_d.viol = r_q.viol | bad;  // R11 sticky
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin           // R1, R12
            r_q.state   <= OH_NORM;
            r_q.ret_ah  <= 1'b0;
            r_q.slp_cnt <= '0;
            r_q.viol    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // R13, R14
    assign state_oh      = r_q.state;
    assign int_clk_en    = ~r_q.state[IX_SLP];
    assign snoop_resp_en = r_q.state[IX_STPG] | r_q.state[IX_AHLT] | r_q.state[IX_SNP];
    assign violation     = r_q.viol;
endmodule

// File: rtl/lps_sequencer_chk.sv
module lps_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] state_oh,
    input logic       snoop_start,
    input logic       snoop_done,
    input logic       violation
);
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1); // R14
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation); // R11
    AST_SNOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[3] && !snoop_done) |=> state_oh[3]); // R4
    AST_SNOOP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[3] && snoop_done) |=> (state_oh[1] || state_oh[2])); // R5
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_oh[4]) |-> $past(state_oh[1])); // R6
    AST_SLEEP_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[4] && snoop_start) |=> violation); // R8
endmodule

bind lps_sequencer lps_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_oh    (state_oh),
    .snoop_start (snoop_start),
    .snoop_done  (snoop_done),
    .violation   (violation)
);

// File: tb/tb_lps_sequencer.sv
`timescale 1ns/1ps
module tb_lps_sequencer;
    localparam int SLP_MIN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stpclk_req = 0, sleep_req = 0, halt_pulse = 0, wake_evt = 0;
    logic snoop_start = 0, snoop_done = 0;
    logic [4:0] state_oh;
    logic int_clk_en, snoop_resp_en, violation;

    int n_chk = 0, n_fail = 0;
    bit started = 0, finished = 0;
    string cur = "R1";

    always #2.5 clk = ~clk;

    lps_sequencer #(.SLP_MIN(SLP_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .stpclk_req(stpclk_req), .sleep_req(sleep_req),
        .halt_pulse(halt_pulse), .wake_evt(wake_evt), .snoop_start(snoop_start),
        .snoop_done(snoop_done), .state_oh(state_oh), .int_clk_en(int_clk_en),
        .snoop_resp_en(snoop_resp_en), .violation(violation)
    );

    // Reference model: 0 Normal, 1 Stop-Grant, 2 AutoHALT, 3 snoop, 4 Sleep
    int  m_st = 0, m_from = 1, m_run = 0;
    bit  m_viol = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_from = 1; m_run = 0; m_viol = 0;
        end else begin
            int nx;
            bit err;
            nx  = m_st;
            err = 0;
            if (sleep_req && m_st != 1 && m_st != 4) err = 1;
            if (m_st == 4 && (snoop_start || snoop_done || halt_pulse || wake_evt || !stpclk_req)) err = 1;
            if (snoop_start && ((m_st == 1 && sleep_req) || (m_st == 4 && !sleep_req))) err = 1;
            if (m_st == 4 && !sleep_req && m_run < SLP_MIN) err = 1;
            case (m_st)
                0: if (stpclk_req) nx = 1; else if (halt_pulse) nx = 2;
                1: if (snoop_start) begin nx = 3; m_from = 1; end
                   else if (sleep_req) nx = 4;
                   else if (!stpclk_req) nx = 0;
                2: if (snoop_start) begin nx = 3; m_from = 2; end
                   else if (wake_evt) nx = 0;
                3: if (snoop_done) nx = m_from;
                default: if (!sleep_req) nx = 1;
            endcase
            m_run  = sleep_req ? ((m_run < SLP_MIN) ? m_run + 1 : m_run) : 0;
            m_st   = nx;
            m_viol = m_viol | err;
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            logic [4:0] e_oh;
            logic e_clk, e_snp;
            e_oh  = 5'(1 << m_st);
            e_clk = (m_st != 4);
            e_snp = (m_st == 1 || m_st == 2 || m_st == 3);
            n_chk++;
            if (state_oh !== e_oh || int_clk_en !== e_clk ||
                snoop_resp_en !== e_snp || violation !== m_viol) begin
                n_fail++;
                $display("FAIL %s t=%0t: got oh=%b clk=%b snp=%b viol=%b, expected oh=%b clk=%b snp=%b viol=%b",
                         cur, $time, state_oh, int_clk_en, snoop_resp_en, violation,
                         e_oh, e_clk, e_snp, m_viol);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic do_reset();
        cur = "R1";
        rst_n = 0; stpclk_req = 0; sleep_req = 0; halt_pulse = 0;
        wake_evt = 0; snoop_start = 0; snoop_done = 0;
        cyc(2);
        rst_n = 1;
        cyc(1);
    endtask

    initial begin
        #20000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(2);
        started = 1;
        cyc(2);
        rst_n = 1; cyc(1);                          // R1
        cur = "R2"; stpclk_req = 1; cyc(2);
        cur = "R3"; stpclk_req = 0; cyc(2);
        cur = "R2"; halt_pulse = 1; cyc(1); halt_pulse = 0; cyc(1);
        cur = "R3"; wake_evt = 1; cyc(1); wake_evt = 0; cyc(1);
        cur = "R2"; stpclk_req = 1; halt_pulse = 1; cyc(1); halt_pulse = 0; cyc(1);
        cur = "R4"; snoop_start = 1; cyc(1); snoop_start = 0; cyc(3);
        cur = "R5"; snoop_done = 1; cyc(1); snoop_done = 0; cyc(1);
        stpclk_req = 0; cyc(1);
        halt_pulse = 1; cyc(1); halt_pulse = 0; cyc(1);
        cur = "R4"; snoop_start = 1; cyc(1); snoop_start = 0; cyc(2);
        cur = "R5"; snoop_done = 1; cyc(1); snoop_done = 0; cyc(1);
        wake_evt = 1; cyc(1); wake_evt = 0; cyc(1);
        cur = "R6"; stpclk_req = 1; cyc(1); sleep_req = 1; cyc(2);
        cur = "R13"; cyc(1);
        cur = "R14"; cyc(1);
        cur = "R6"; sleep_req = 0; cyc(2);
        cur = "R10"; sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
        cur = "R11"; stpclk_req = 0; cyc(3);
        do_reset();
        cur = "R12"; stpclk_req = 1; cyc(1); sleep_req = 1; cyc(3);
        rst_n = 0; sleep_req = 0; stpclk_req = 0; cyc(1); rst_n = 1; cyc(2);
        cur = "R7"; sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
        do_reset();
        cur = "R8"; stpclk_req = 1; cyc(1); sleep_req = 1; cyc(3);
        wake_evt = 1; cyc(1); wake_evt = 0; cyc(2);
        sleep_req = 0; cyc(2);
        do_reset();
        cur = "R9"; stpclk_req = 1; cyc(1);
        sleep_req = 1; snoop_start = 1; cyc(1); sleep_req = 0; snoop_start = 0; cyc(1);
        snoop_done = 1; cyc(1); snoop_done = 0; cyc(2);
        do_reset();
        cyc(1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule